// File: doc/BRIEF.md
# Write-to-Read Turnaround Wait-State Gate

This block sits between the access sequencer of a static memory controller and the external bus pins. Each clock the sequencer may offer one access (a read or a write) with its address, write data, byte selects and timing settings. An accepted access is driven onto the registered pin outputs at the next clock edge. When a read is offered in the cycle right after a write was accepted, the gate may refuse it for one cycle. In that cycle it raises `stall`, keeps the address, data and byte-select pins as they were, and lets the write strobe go inactive, so that the write finishes cleanly before the read starts.

The decision depends on how the preceding write was programmed. If chip select frames the write and both its chip-select hold count and the next read's chip-select setup count are zero, a wait cycle is always added. In that cycle chip select rises, which closes the write. If the write strobe frames the write and its strobe hold count is zero, the gate uses the observed level of the external write strobe. This level comes from a feedback pin through a two-flop synchronizer. A level that still reads low (active) adds the wait cycle, and chip select then stays low through it. The sequencer re-offers the refused read on the next cycle, and the gate accepts it.

Top module: `sm_early_read_gate`

## Requirements
- R1: While `rst_n` is low, and at release, `mem_cs_n`, `mem_we_n` and `mem_rd_n` are 1, `mem_bs_n` is all ones, `mem_addr` and `mem_data` are zero, and `stall` is 0.
- R2: An offered access that is not stalled appears on the pins after the next rising clock edge. `mem_cs_n` is 0, `mem_addr` and `mem_bs_n` (the inverse of `req_bsel`) are loaded, and then either `mem_we_n`=0 with `mem_rd_n`=1 and `mem_data` loaded (write) or `mem_rd_n`=0 with `mem_we_n`=1 (read).
- R3: With `wr_mode`=0 (chip-select framed), the previous write had `wr_cs_hold`=0, and the offered read has `rd_cs_setup`=0: `stall` is 1 and `mem_cs_n` is 1 during the wait cycle.
- R4: With `wr_mode`=1 (strobe framed), the previous write had `wr_we_hold`=0, and the synchronized feedback reads 0: `stall` is 1 whatever `rd_cs_setup` is, and `mem_cs_n` stays 0 during the wait cycle.
- R5: In strobe-framed mode with zero strobe hold, a synchronized feedback of 1 gives no stall.
- R6: A non-zero `wr_cs_hold` (chip-select framed), a non-zero `rd_cs_setup` (chip-select framed) or a non-zero `wr_we_hold` (strobe framed) gives no stall.
- R7: No stall is raised for read after read, write after write, read after write with an idle cycle between them, or read followed by write.
- R8: During a wait cycle `mem_addr`, `mem_data` and `mem_bs_n` keep their values, and `mem_we_n` and `mem_rd_n` are 1.
- R9: `stall` is never high on two consecutive cycles. A read re-offered right after a wait cycle is accepted.
- R10: The feedback used in the cycle after write-accept edge k is the `we_fb_n` level sampled at edge k-1 (two-flop synchronizer, reset to 1).
- R11: In a cycle with no offered access and no stall, the next edge drives `mem_cs_n`, `mem_we_n` and `mem_rd_n` to 1 and leaves address, data and byte selects unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is offered this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Access address |
| req_data | input | 32 | Write data |
| req_bsel | input | 4 | Byte enables, active high |
| wr_mode | input | 1 | Write framing of the offered write: 0 chip select, 1 write strobe |
| wr_cs_hold | input | 4 | Chip-select hold count of the offered write |
| wr_we_hold | input | 4 | Write-strobe hold count of the offered write |
| rd_cs_setup | input | 4 | Chip-select setup count of the offered read |
| we_fb_n | input | 1 | Observed level of the external write strobe, asynchronous |
| stall | output | 1 | Offered read refused this cycle, wait cycle inserted |
| mem_addr | output | 24 | Registered address pins |
| mem_data | output | 32 | Registered write-data pins |
| mem_bs_n | output | 4 | Registered byte selects, active low |
| mem_cs_n | output | 1 | Registered chip select, active low |
| mem_we_n | output | 1 | Registered write strobe, active low |
| mem_rd_n | output | 1 | Registered read strobe, active low |

## Verification
The hardest case to reach is the strobe-framed stall. Whether it happens depends on a feedback level that was sampled one edge before the write was even accepted. The stimulus therefore sets the feedback pin one cycle ahead of each write. It also runs paired cases in which the low level lands only on the edge before acceptance, or only on the acceptance edge, which pins down the synchronizer depth. A reference model in the bench follows every cycle, including the re-offered read after each stall. Back-to-back write/read sequences are mixed with idle gaps and with non-zero hold and setup values.

// File: rtl/erw_pkg.sv
package erw_pkg;
  typedef enum logic {
    WR_BY_CS     = 1'b0,
    WR_BY_STROBE = 1'b1
  } wr_ctl_e;

  typedef struct packed {
    logic    valid;
    wr_ctl_e mode;
    logic    cs_hold_zero;
    logic    we_hold_zero;
  } last_wr_t;
endpackage

// File: rtl/erw_fb_sync.sv
module erw_fb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic d_in;
      if (i == 0) begin : g_first
        assign d_in = async_n;
      end else begin : g_next
        assign d_in = chain_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b1;
        else        chain_q[i] <= d_in;
      end
    end
  endgenerate

  assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/erw_gap_decide.sv
module erw_gap_decide
  import erw_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             wr_mode,
  input  logic [CNT_W-1:0] wr_cs_hold,
  input  logic [CNT_W-1:0] wr_we_hold,
  input  logic [CNT_W-1:0] rd_cs_setup,
  input  logic             fb_sync_n,
  output logic             stall,
  output logic             accept,
  output wr_ctl_e          last_mode
);
  last_wr_t last_q, last_d;
  logic     rd_offer;
  logic     cs_case;
  logic     we_case;

  always_comb begin
    rd_offer = req_valid && !req_write;
    cs_case  = (last_q.mode == WR_BY_CS) && last_q.cs_hold_zero &&
               (rd_cs_setup == '0);
    we_case  = (last_q.mode == WR_BY_STROBE) && last_q.we_hold_zero &&
               !fb_sync_n;
    stall    = last_q.valid && rd_offer && (cs_case || we_case);
    accept   = req_valid && !stall;
  end

  always_comb begin
    last_d = last_q;
    if (accept) begin
      last_d.valid        = req_write;
      last_d.mode         = wr_ctl_e'(wr_mode);
      last_d.cs_hold_zero = (wr_cs_hold == '0);
      last_d.we_hold_zero = (wr_we_hold == '0);
    end else begin
      last_d.valid = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '{valid: 1'b0, mode: WR_BY_CS, cs_hold_zero: 1'b0, we_hold_zero: 1'b0};
    end else begin
      last_q <= last_d;
    end
  end

  assign last_mode = last_q.mode;
endmodule

// File: rtl/erw_pin_reg.sv
module erw_pin_reg
  import erw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int BS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              stall,
  input  wr_ctl_e           last_mode,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [BS_W-1:0]   req_bsel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BS_W-1:0]   mem_bs_n,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_rd_n
);
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  logic [BS_W-1:0]   bs_d;
  logic              cs_d, we_d, rd_d;
  logic              addr_en, data_en;

  always_comb begin
    addr_en = accept;
    data_en = accept && req_write;
    addr_d  = req_addr;
    data_d  = req_data;
    bs_d    = ~req_bsel;
    we_d    = 1'b1;
    rd_d    = 1'b1;
    cs_d    = 1'b1;
    if (accept) begin
      cs_d = 1'b0;
      we_d = !req_write;
      rd_d = req_write;
    end else if (stall) begin
      cs_d = (last_mode == WR_BY_STROBE) ? mem_cs_n : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_bs_n <= '1;
    end else if (addr_en) begin
      mem_addr <= addr_d;
      mem_bs_n <= bs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mem_data <= '0;
    else if (data_en) mem_data <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_rd_n <= 1'b1;
    end else begin
      mem_cs_n <= cs_d;
      mem_we_n <= we_d;
      mem_rd_n <= rd_d;
    end
  end
endmodule

// File: rtl/sm_early_read_gate.sv
module sm_early_read_gate
  import erw_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter int BS_W        = 4,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [BS_W-1:0]   req_bsel,
  input  logic              wr_mode,
  input  logic [CNT_W-1:0]  wr_cs_hold,
  input  logic [CNT_W-1:0]  wr_we_hold,
  input  logic [CNT_W-1:0]  rd_cs_setup,
  input  logic              we_fb_n,
  output logic              stall,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BS_W-1:0]   mem_bs_n,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_rd_n
);
  logic    fb_sync_n;
  logic    accept;
  wr_ctl_e last_mode;

  erw_fb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (we_fb_n),
    .sync_n  (fb_sync_n)
  );

  erw_gap_decide #(.CNT_W(CNT_W)) u_decide (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .wr_mode     (wr_mode),
    .wr_cs_hold  (wr_cs_hold),
    .wr_we_hold  (wr_we_hold),
    .rd_cs_setup (rd_cs_setup),
    .fb_sync_n   (fb_sync_n),
    .stall       (stall),
    .accept      (accept),
    .last_mode   (last_mode)
  );

  erw_pin_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BS_W(BS_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .stall     (stall),
    .last_mode (last_mode),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_bsel  (req_bsel),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_bs_n  (mem_bs_n),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_rd_n  (mem_rd_n)
  );
endmodule

// File: rtl/erw_checker.sv
module erw_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int BS_W   = 4,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              wr_mode,
  input logic [CNT_W-1:0]  wr_cs_hold,
  input logic [CNT_W-1:0]  rd_cs_setup,
  input logic              stall,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [BS_W-1:0]   mem_bs_n,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_rd_n
);
  a_r9_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  a_r8_pins_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(mem_addr) && $stable(mem_data) && $stable(mem_bs_n)
               && mem_we_n && mem_rd_n));

  a_r7_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!mem_we_n && req_valid && !req_write));

  a_r3_cs_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !$past(wr_mode)) |=> mem_cs_n);

  a_r4_cs_kept_low: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(wr_mode)) |=> !mem_cs_n);

  a_r6_cs_zero_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !$past(wr_mode)) |-> (rd_cs_setup == '0 && $past(wr_cs_hold) == '0));

  a_r2_accept_drives_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !stall) |=> !mem_cs_n);
endmodule

bind sm_early_read_gate erw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BS_W(BS_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .wr_mode     (wr_mode),
  .wr_cs_hold  (wr_cs_hold),
  .rd_cs_setup (rd_cs_setup),
  .stall       (stall),
  .mem_addr    (mem_addr),
  .mem_data    (mem_data),
  .mem_bs_n    (mem_bs_n),
  .mem_cs_n    (mem_cs_n),
  .mem_we_n    (mem_we_n),
  .mem_rd_n    (mem_rd_n)
);

// File: tb/sm_early_read_gate_test.sv
module sm_early_read_gate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, wr_mode, we_fb_n;
  logic [23:0] req_addr;
  logic [31:0] req_data;
  logic [3:0]  req_bsel, wr_cs_hold, wr_we_hold, rd_cs_setup;
  logic        stall, mem_cs_n, mem_we_n, mem_rd_n;
  logic [23:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0]  mem_bs_n;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int seq   = 0;

  // reference model state
  logic [23:0] m_addr;
  logic [31:0] m_data;
  logic [3:0]  m_bs_n;
  logic        m_cs_n, m_we_n, m_rd_n;
  bit          p_wr, p_mode, p_csh0, p_weh0;
  logic        h1, h2;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm_early_read_gate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data), .req_bsel(req_bsel),
    .wr_mode(wr_mode), .wr_cs_hold(wr_cs_hold), .wr_we_hold(wr_we_hold),
    .rd_cs_setup(rd_cs_setup), .we_fb_n(we_fb_n), .stall(stall),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_bs_n(mem_bs_n),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_rd_n(mem_rd_n)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_pins(input string tag);
    chk(tag, "mem_addr", 64'(mem_addr), 64'(m_addr));
    chk(tag, "mem_data", 64'(mem_data), 64'(m_data));
    chk(tag, "mem_bs_n", 64'(mem_bs_n), 64'(m_bs_n));
    chk(tag, "mem_cs_n", 64'(mem_cs_n), 64'(m_cs_n));
    chk(tag, "mem_we_n", 64'(mem_we_n), 64'(m_we_n));
    chk(tag, "mem_rd_n", 64'(mem_rd_n), 64'(m_rd_n));
  endtask

  // One cycle: check pins, drive, check stall, advance model at the edge.
  task automatic step(input string tag, input bit v, input bit w, input bit md,
                      input logic [3:0] ch, input logic [3:0] wh,
                      input logic [3:0] rs, input bit fb, input bit exp_st);
    bit st, acc;
    @(negedge clk);
    chk_pins(tag);
    seq++;
    req_valid = v; req_write = w; wr_mode = md;
    wr_cs_hold = ch; wr_we_hold = wh; rd_cs_setup = rs; we_fb_n = fb;
    req_addr = 24'h100000 + 24'(seq * 24'h313);
    req_data = 32'hA5000000 ^ 32'(seq * 32'h10203);
    req_bsel = 4'(seq * 5 + 1);
    #1;
    st  = p_wr && v && !w &&
          ((!p_mode && p_csh0 && rs == 0) || (p_mode && p_weh0 && h2 == 1'b0));
    acc = v && !st;
    chk(tag, "stall", 64'(stall), 64'(st));
    chk(tag, "stall plan", 64'(st), 64'(exp_st));
    @(posedge clk);
    if (acc) begin
      m_addr = req_addr;
      if (w) m_data = req_data;
      m_bs_n = ~req_bsel;
      m_cs_n = 1'b0; m_we_n = !w; m_rd_n = w;
      p_wr = w; p_mode = md; p_csh0 = (ch == 0); p_weh0 = (wh == 0);
    end else if (st) begin
      m_we_n = 1'b1; m_rd_n = 1'b1;
      m_cs_n = p_mode ? m_cs_n : 1'b1;
      p_wr = 0;
    end else begin
      m_cs_n = 1'b1; m_we_n = 1'b1; m_rd_n = 1'b1;
      p_wr = 0;
    end
    h2 = h1; h1 = fb;
  endtask

  task automatic wr(input string tag, input bit md, input logic [3:0] ch,
                    input logic [3:0] wh, input bit fb);
    step(tag, 1, 1, md, ch, wh, 4'd0, fb, 0);
  endtask

  task automatic rd(input string tag, input logic [3:0] rs, input bit fb,
                    input bit exp_st);
    step(tag, 1, 0, 0, 4'd0, 4'd0, rs, fb, exp_st);
  endtask

  task automatic idle(input string tag, input bit fb);
    step(tag, 0, 0, 0, 4'd0, 4'd0, 4'd0, fb, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; wr_mode = 0; we_fb_n = 1'b1;
    req_addr = '0; req_data = '0; req_bsel = '0;
    wr_cs_hold = '0; wr_we_hold = '0; rd_cs_setup = '0;
    m_addr = '0; m_data = '0; m_bs_n = 4'hF;
    m_cs_n = 1; m_we_n = 1; m_rd_n = 1;
    p_wr = 0; p_mode = 0; p_csh0 = 0; p_weh0 = 0; h1 = 1; h2 = 1;
    repeat (3) @(negedge clk);
    chk_pins("R1");
    chk("R1", "stall", 64'(stall), 64'd0);
    rst_n = 1'b1;

    // R2 plain write then read with non-zero setup, R11 idle
    wr("R2", 0, 4'd1, 4'd0, 1);
    idle("R11", 1);
    rd("R2", 4'd2, 1, 0);
    idle("R11", 1);

    // R3 chip-select framed, all zero: one wait cycle, R9 read accepted after
    wr("R3", 0, 4'd0, 4'd0, 1);
    rd("R3", 4'd0, 1, 1);
    rd("R9", 4'd0, 1, 0);
    idle("R8", 1);

    // R6 non-zero counts
    wr("R6", 0, 4'd2, 4'd0, 1);
    rd("R6", 4'd0, 1, 0);
    wr("R6", 0, 4'd0, 4'd0, 1);
    rd("R6", 4'd1, 1, 0);
    idle("R6", 0);
    wr("R6", 1, 4'd0, 4'd3, 0);
    rd("R6", 4'd0, 0, 0);
    idle("R6", 1);

    // R4 strobe framed, feedback low: wait cycle with cs low
    idle("R4", 0);
    wr("R4", 1, 4'd0, 4'd0, 0);
    rd("R4", 4'd5, 0, 1);
    rd("R9", 4'd5, 1, 0);
    idle("R8", 1);

    // R5 strobe framed, feedback high
    idle("R5", 1);
    wr("R5", 1, 4'd0, 4'd0, 1);
    rd("R5", 4'd0, 1, 0);

    // R10 synchronizer depth
    idle("R10", 1);
    wr("R10", 1, 4'd0, 4'd0, 0);
    rd("R10", 4'd0, 0, 0);
    idle("R10", 0);
    wr("R10", 1, 4'd0, 4'd0, 1);
    rd("R10", 4'd0, 1, 1);
    rd("R10", 4'd0, 1, 0);

    // R7 sequences that never stall
    rd("R7", 4'd0, 1, 0);
    rd("R7", 4'd0, 1, 0);
    wr("R7", 0, 4'd0, 4'd0, 1);
    wr("R7", 0, 4'd0, 4'd0, 1);
    idle("R7", 1);
    rd("R7", 4'd0, 1, 0);
    wr("R7", 0, 4'd0, 4'd0, 1);
    rd("R3", 4'd0, 1, 1);
    rd("R9", 4'd0, 1, 0);
    idle("R11", 1);
    idle("R11", 1);

    @(negedge clk);
    chk_pins("R11");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule